// File: doc/BRIEF.md
# JTAG In-System Programming Flash Ownership Controller

This block sits between a JTAG test access port and a shared 16-bit flash bus. Three parties can use that bus: an internal configuration reader that streams the bitstream into an attached FPGA, an external processor or FPGA that uses a parallel port, and the JTAG programming path. The TAP logic decodes a small instruction set. One instruction pulls the FPGA configuration-init line low, which holds the FPGA in reset and cancels any read by the internal reader. A second instruction gives the bus to the JTAG path and shuts out the external port. A third instruction lets the init line go and fires a one-cycle strobe, so that configuration restarts from the newly written flash image.

The block has one system clock. TCK, TMS, TDI and the two flash-side request lines pass through two-flop synchronisers into that clock domain. The block then finds the TCK edges by oversampling, so the TAP works with TCK up to about 10 MHz. The init line is modelled as an open-drain pin: a value that is always low, plus a separate output enable. Every grant, every bus enable and the bus data are registered.

Top module: `flash_isp_ctrl`

## Requirements
- R1: After the synchronous reset, `cfg_init_oe`, `reconfig_start`, `tdo_oe`, `flash_dq_oe` and all three grants are low. `cfg_init_n` is always 0, so the resolved init line is high while `cfg_init_oe` is low.
- R2: Five TCK rising edges with TMS high bring the TAP to Test-Logic-Reset from any state. A scan that then leaves through Run-Test/Idle works normally.
- R3: Capture-IR loads 4'b0001 into the 4-bit instruction shift register. The bits leave on TDO least significant bit first. TDO changes on falling TCK, and `tdo_oe` is high only while the TAP is in Shift-IR or Shift-DR.
- R4: Every instruction selects a 1-bit bypass data register that captures 0 in Capture-DR, so TDO repeats TDI one TCK later. Codes other than 4'h1, 4'h2 and 4'h3 (for example 4'hF and 4'h7) change neither the hold nor the ownership.
- R5: When code 4'h1 (hold) reaches Update-IR, `cfg_init_oe` goes high and `int_gnt` is withdrawn. The internal reader gets no grant again while the hold lasts.
- R6: Code 4'h2 (initiate configuration) at Update-IR releases the hold and ends any programming session. Apart from R9, it is the only way to release the hold.
- R7: Each release of an active hold pulses `reconfig_start` high for exactly one clock. When the hold was not active, code 4'h2 gives no pulse.
- R8: After code 4'h3 (programming) reaches Update-IR, `jtag_gnt` is 1 and `ext_gnt` and `int_gnt` are 0 whatever the requests. The external port's write enable does not reach `flash_dq_oe`, and `ext_rdata` reads 0.
- R9: Test-Logic-Reset releases an active hold, with the R7 pulse, only when no programming session is active. During a session the hold and `jtag_gnt` stay.
- R10: Without a programming session, a pending external request wins. The internal reader is granted only while the external request is low and no hold is active. The hold does not block the external port.
- R11: `flash_dq_o` and `flash_dq_oe` carry the owner's write data and write enable: `ext_wdata`/`ext_wen` for the external port and `jtag_wdata`/`jtag_wen` for JTAG. The internal reader never drives the bus. `ext_rdata` returns `flash_dq_i` only while the external port owns the bus, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tck | input | 1 | JTAG test clock (oversampled) |
| tms | input | 1 | JTAG mode select |
| tdi | input | 1 | JTAG serial data in |
| tdo | output | 1 | JTAG serial data out |
| tdo_oe | output | 1 | TDO drive enable |
| cfg_init_n | output | 1 | Open-drain value of the configuration-init line (always 0) |
| cfg_init_oe | output | 1 | Pulls the init line low when 1 (FPGA held) |
| reconfig_start | output | 1 | One-clock strobe that starts a new configuration |
| ext_req | input | 1 | External parallel port requests the bus (asynchronous) |
| ext_gnt | output | 1 | External port owns the bus |
| ext_wen | input | 1 | External port wants to drive the bus |
| ext_wdata | input | 16 | External port write data |
| ext_rdata | output | 16 | Bus read data returned to the external port |
| int_req | input | 1 | Internal configuration reader requests the bus (asynchronous) |
| int_gnt | output | 1 | Internal reader owns the bus |
| jtag_wen | input | 1 | JTAG programming engine wants to drive the bus |
| jtag_wdata | input | 16 | JTAG programming engine write data |
| jtag_gnt | output | 1 | JTAG path owns the bus |
| flash_dq_i | input | 16 | Flash data bus, input side |
| flash_dq_o | output | 16 | Flash data bus, output side |
| flash_dq_oe | output | 16 | Flash data bus tri-state enable, replicated per bit |

## Verification
A release of the hold and a handoff of bus ownership take place together. The initiate-configuration instruction is loaded while the hold is active and while the external and internal requests are both asserted. The bench then checks that exactly one `reconfig_start` pulse occurs and that the freed bus goes to the external port, not to the reader that the hold had blocked. A second case enters Test-Logic-Reset during a programming session. The bench checks that the reset of the TAP neither releases the hold nor takes the bus away from the JTAG path.

// File: rtl/isp_pkg.sv
package isp_pkg;

  localparam int IR_W = 4;

  localparam logic [IR_W-1:0] OP_HOLD    = 4'h1;
  localparam logic [IR_W-1:0] OP_RELEASE = 4'h2;
  localparam logic [IR_W-1:0] OP_PROG    = 4'h3;
  localparam logic [IR_W-1:0] OP_BYPASS  = 4'hF;
  localparam logic [IR_W-1:0] IR_CAPTURE = 4'b0001;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PA_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PA_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_t;

  typedef enum logic [1:0] {
    OWN_NONE, OWN_EXT, OWN_INT, OWN_JTAG
  } owner_t;

endpackage

// File: rtl/isp_sync.sv
module isp_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int PW = W * STAGES;

  logic [PW-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= '0;
    else     pipe <= {pipe[PW-W-1:0], d};
  end

  assign q = pipe[PW-1 -: W];

  initial begin
    assert (STAGES >= 2) else $error("synchroniser needs two stages");
  end
endmodule

// File: rtl/isp_tap.sv
module isp_tap
  import isp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tck_rise,
  input  logic       tms,
  output tap_state_t state
);
  tap_state_t nxt;

  always_comb begin
    unique case (state)
      ST_RESET:  nxt = tms ? ST_RESET  : ST_IDLE;
      ST_IDLE:   nxt = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PA_DR;
      ST_PA_DR:  nxt = tms ? ST_EX2_DR : ST_PA_DR;
      ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: nxt = tms ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PA_IR;
      ST_PA_IR:  nxt = tms ? ST_EX2_IR : ST_PA_IR;
      ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: nxt = tms ? ST_SEL_DR : ST_IDLE;
      default:   nxt = ST_RESET;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)           state <= ST_RESET;
    else if (tck_rise) state <= nxt;
  end

  // R2: the TAP only moves on a detected TCK rising edge
  p_tap_moves_on_tck_r2: assert property (@(posedge clk) disable iff (rst)
    !tck_rise |=> $stable(state));
endmodule

// File: rtl/isp_ir.sv
module isp_ir
  import isp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tck_rise,
  input  logic       tck_fall,
  input  logic       tdi,
  input  tap_state_t state,
  output logic       tdo,
  output logic       tdo_oe,
  output logic       upd_hold,
  output logic       upd_release,
  output logic       upd_prog,
  output logic       in_reset
);
  logic [IR_W-1:0] ir_sr;
  logic            bp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ir_sr       <= OP_BYPASS;
      bp_q        <= 1'b0;
      tdo         <= 1'b0;
      tdo_oe      <= 1'b0;
      upd_hold    <= 1'b0;
      upd_release <= 1'b0;
      upd_prog    <= 1'b0;
    end else begin
      upd_hold    <= 1'b0;
      upd_release <= 1'b0;
      upd_prog    <= 1'b0;
      if (tck_rise) begin
        unique case (state)
          ST_CAP_IR: ir_sr <= IR_CAPTURE;
          ST_SH_IR:  ir_sr <= {tdi, ir_sr[IR_W-1:1]};
          ST_CAP_DR: bp_q  <= 1'b0;
          ST_SH_DR:  bp_q  <= tdi;
          default:   ;
        endcase
      end
      if (tck_fall) begin
        tdo_oe <= (state == ST_SH_IR) || (state == ST_SH_DR);
        tdo    <= (state == ST_SH_IR) ? ir_sr[0] : bp_q;
        if (state == ST_UPD_IR) begin
          unique case (ir_sr)
            OP_HOLD:    upd_hold    <= 1'b1;
            OP_RELEASE: upd_release <= 1'b1;
            OP_PROG:    upd_prog    <= 1'b1;
            default:    ;
          endcase
        end
      end
    end
  end

  assign in_reset = (state == ST_RESET);

  // R3: TDO is enabled only after a falling edge seen in a shift state
  p_tdo_oe_shift_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(tdo_oe) |-> $past(tck_fall) &&
      ($past(state) == ST_SH_IR || $past(state) == ST_SH_DR));
  // R6: decode strobes are mutually exclusive
  p_one_update_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({upd_hold, upd_release, upd_prog}));
endmodule

// File: rtl/isp_arb.sv
module isp_arb
  import isp_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd_hold,
  input  logic              upd_release,
  input  logic              upd_prog,
  input  logic              in_reset,
  input  logic              ext_req_s,
  input  logic              int_req_s,
  input  logic              ext_wen,
  input  logic [DATA_W-1:0] ext_wdata,
  input  logic              jtag_wen,
  input  logic [DATA_W-1:0] jtag_wdata,
  input  logic [DATA_W-1:0] flash_dq_i,
  output logic              hold_oe,
  output logic              reconfig_start,
  output logic              ext_gnt,
  output logic              int_gnt,
  output logic              jtag_gnt,
  output logic [DATA_W-1:0] ext_rdata,
  output logic [DATA_W-1:0] flash_dq_o,
  output logic              flash_dq_oe
);
  logic   hold_q;
  logic   prog_q;
  logic   release_c;
  owner_t owner_c;

  assign release_c = hold_q && (upd_release || (in_reset && !prog_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q         <= 1'b0;
      prog_q         <= 1'b0;
      reconfig_start <= 1'b0;
    end else begin
      reconfig_start <= release_c;
      if (upd_hold)       hold_q <= 1'b1;
      else if (release_c) hold_q <= 1'b0;
      if (upd_prog)         prog_q <= 1'b1;
      else if (upd_release) prog_q <= 1'b0;
    end
  end

  always_comb begin
    if (prog_q)                    owner_c = OWN_JTAG;
    else if (ext_req_s)            owner_c = OWN_EXT;
    else if (int_req_s && !hold_q) owner_c = OWN_INT;
    else                           owner_c = OWN_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ext_gnt     <= 1'b0;
      int_gnt     <= 1'b0;
      jtag_gnt    <= 1'b0;
      flash_dq_oe <= 1'b0;
      flash_dq_o  <= '0;
      ext_rdata   <= '0;
    end else begin
      ext_gnt     <= (owner_c == OWN_EXT);
      int_gnt     <= (owner_c == OWN_INT);
      jtag_gnt    <= (owner_c == OWN_JTAG);
      flash_dq_oe <= ((owner_c == OWN_EXT) && ext_wen) ||
                     ((owner_c == OWN_JTAG) && jtag_wen);
      flash_dq_o  <= (owner_c == OWN_JTAG) ? jtag_wdata :
                     (owner_c == OWN_EXT)  ? ext_wdata  : '0;
      ext_rdata   <= (owner_c == OWN_EXT) ? flash_dq_i : '0;
    end
  end

  assign hold_oe = hold_q;

  // R5: an active hold leaves the internal reader without a grant
  p_hold_blocks_reader_r5: assert property (@(posedge clk) disable iff (rst)
    hold_q |=> !int_gnt);
  // R8: a programming session owns the bus exclusively
  p_prog_exclusive_r8: assert property (@(posedge clk) disable iff (rst)
    prog_q |=> jtag_gnt && !ext_gnt && !int_gnt);
  // R8: the external write enable cannot reach the bus during a session
  p_prog_no_ext_drive_r8: assert property (@(posedge clk) disable iff (rst)
    prog_q && !jtag_wen |=> !flash_dq_oe);
  // R10: at most one owner at a time
  p_single_owner_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ext_gnt, int_gnt, jtag_gnt}));
  // R7: the restart strobe lasts one clock
  p_strobe_one_cycle_r7: assert property (@(posedge clk) disable iff (rst)
    reconfig_start |=> !reconfig_start);
  // R6: the hold only drops after a release request
  p_release_cause_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(hold_q) |-> $past(upd_release || (in_reset && !prog_q)));
endmodule

// File: rtl/flash_isp_ctrl.sv
module flash_isp_ctrl
  import isp_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tck,
  input  logic              tms,
  input  logic              tdi,
  output logic              tdo,
  output logic              tdo_oe,
  output logic              cfg_init_n,
  output logic              cfg_init_oe,
  output logic              reconfig_start,
  input  logic              ext_req,
  output logic              ext_gnt,
  input  logic              ext_wen,
  input  logic [DATA_W-1:0] ext_wdata,
  output logic [DATA_W-1:0] ext_rdata,
  input  logic              int_req,
  output logic              int_gnt,
  input  logic              jtag_wen,
  input  logic [DATA_W-1:0] jtag_wdata,
  output logic              jtag_gnt,
  input  logic [DATA_W-1:0] flash_dq_i,
  output logic [DATA_W-1:0] flash_dq_o,
  output logic [DATA_W-1:0] flash_dq_oe
);
  localparam int JTAG_PINS = 3;
  localparam int REQ_PINS  = 2;

  logic [JTAG_PINS-1:0] jtag_s;
  logic [REQ_PINS-1:0]  req_s;
  logic                 tck_d;
  logic                 tck_rise;
  logic                 tck_fall;
  tap_state_t           state;
  logic                 upd_hold, upd_release, upd_prog, in_reset;
  logic                 dq_oe_1;

  isp_sync #(.W(JTAG_PINS), .STAGES(SYNC_STAGES)) u_jtag_sync (
    .clk(clk), .rst(rst), .d({tck, tms, tdi}), .q(jtag_s));

  isp_sync #(.W(REQ_PINS), .STAGES(SYNC_STAGES)) u_req_sync (
    .clk(clk), .rst(rst), .d({ext_req, int_req}), .q(req_s));

  always_ff @(posedge clk) begin
    if (rst) tck_d <= 1'b0;
    else     tck_d <= jtag_s[2];
  end

  assign tck_rise = jtag_s[2] && !tck_d;
  assign tck_fall = !jtag_s[2] && tck_d;

  isp_tap u_tap (
    .clk(clk), .rst(rst), .tck_rise(tck_rise), .tms(jtag_s[1]), .state(state));

  isp_ir u_ir (
    .clk(clk), .rst(rst), .tck_rise(tck_rise), .tck_fall(tck_fall),
    .tdi(jtag_s[0]), .state(state), .tdo(tdo), .tdo_oe(tdo_oe),
    .upd_hold(upd_hold), .upd_release(upd_release), .upd_prog(upd_prog),
    .in_reset(in_reset));

  isp_arb #(.DATA_W(DATA_W)) u_arb (
    .clk(clk), .rst(rst),
    .upd_hold(upd_hold), .upd_release(upd_release), .upd_prog(upd_prog),
    .in_reset(in_reset), .ext_req_s(req_s[1]), .int_req_s(req_s[0]),
    .ext_wen(ext_wen), .ext_wdata(ext_wdata),
    .jtag_wen(jtag_wen), .jtag_wdata(jtag_wdata), .flash_dq_i(flash_dq_i),
    .hold_oe(cfg_init_oe), .reconfig_start(reconfig_start),
    .ext_gnt(ext_gnt), .int_gnt(int_gnt), .jtag_gnt(jtag_gnt),
    .ext_rdata(ext_rdata), .flash_dq_o(flash_dq_o), .flash_dq_oe(dq_oe_1));

  assign flash_dq_oe = {DATA_W{dq_oe_1}};
  assign cfg_init_n  = 1'b0;
endmodule

// File: tb/flash_isp_ctrl_tb_top.sv
module flash_isp_ctrl_tb_top;
  localparam int DW     = 16;
  localparam int HALF   = 48;
  localparam int NVEC   = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tck = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic tdo, tdo_oe, cfg_init_n, cfg_init_oe, reconfig_start;
  logic ext_req = 1'b0, int_req = 1'b0, ext_wen = 1'b0, jtag_wen = 1'b0;
  logic [DW-1:0] ext_wdata = '0, jtag_wdata = '0, flash_dq_i = '0;
  logic [DW-1:0] ext_rdata, flash_dq_o, flash_dq_oe;
  logic ext_gnt, int_gnt, jtag_gnt;

  int n_chk = 0, n_fail = 0, pulses = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  flash_isp_ctrl dut_i (
    .clk(clk), .rst(rst), .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo),
    .tdo_oe(tdo_oe), .cfg_init_n(cfg_init_n), .cfg_init_oe(cfg_init_oe),
    .reconfig_start(reconfig_start), .ext_req(ext_req), .ext_gnt(ext_gnt),
    .ext_wen(ext_wen), .ext_wdata(ext_wdata), .ext_rdata(ext_rdata),
    .int_req(int_req), .int_gnt(int_gnt), .jtag_wen(jtag_wen),
    .jtag_wdata(jtag_wdata), .jtag_gnt(jtag_gnt), .flash_dq_i(flash_dq_i),
    .flash_dq_o(flash_dq_o), .flash_dq_oe(flash_dq_oe));

  always @(negedge clk) if (!rst && reconfig_start) pulses++;

  // {op[3:0], ext_req, int_req, hold, ext_gnt, int_gnt, jtag_gnt, pulses[1:0]}
  localparam logic [11:0] VEC [NVEC] = '{
    {4'hF, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0},
    {4'hF, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0},
    {4'h1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0},
    {4'h1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0},
    {4'h3, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 2'd0},
    {4'h7, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 2'd0},
    {4'h2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 2'd1},
    {4'h2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0},
    {4'h3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0},
    {4'h2, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0}
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic tick(input logic m, input logic d, output logic o, output logic oe);
    tck = 1'b0; tms = m; tdi = d;
    #HALF;
    o = tdo; oe = tdo_oe;
    tck = 1'b1;
    #HALF;
  endtask

  task automatic ir_scan(input logic [3:0] op, output logic [3:0] cap, output logic [3:0] oes);
    logic o, e;
    tick(1, 0, o, e); tick(1, 0, o, e); tick(0, 0, o, e); tick(0, 0, o, e);
    for (int i = 0; i < 4; i++) begin
      tick(i == 3, op[i], o, e);
      cap[i] = o; oes[i] = e;
    end
    tick(1, 0, o, e); tick(0, 0, o, e);
  endtask

  task automatic load(input logic [3:0] op);
    logic [3:0] c, e;
    ir_scan(op, c, e);
    repeat (20) @(negedge clk);
  endtask

  task automatic reset_from_dr();
    logic o, e;
    tick(1, 0, o, e); tick(0, 0, o, e); tick(0, 0, o, e);
    for (int i = 0; i < 5; i++) tick(1, 0, o, e);
    tick(0, 0, o, e);
    repeat (20) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic o, e;
    logic [3:0] cap, oes, bits;
    int p0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 init_oe", cfg_init_oe, 0);
    chk("R1 init line", cfg_init_oe ? cfg_init_n : 1'b1, 1);
    chk("R1 strobe", reconfig_start, 0);
    chk("R1 tdo_oe", tdo_oe, 0);
    chk("R1 dq_oe", flash_dq_oe, 0);
    chk("R1 grants", {ext_gnt, int_gnt, jtag_gnt}, 0);
    tick(0, 0, o, e);

    // R3 capture pattern
    ir_scan(4'hF, cap, oes);
    chk("R3 capture", cap, 4'b0001);
    chk("R3 oe in shift", oes, 4'hF);
    repeat (20) @(negedge clk);
    chk("R3 oe after", tdo_oe, 0);

    // R4 bypass delay
    tick(1, 0, o, e); tick(0, 0, o, e); tick(0, 0, o, e);
    for (int i = 0; i < 4; i++) begin
      tick(i == 3, (4'b1101 >> i) & 1'b1, o, e);
      bits[i] = o;
    end
    tick(1, 0, o, e); tick(0, 0, o, e);
    chk("R4 bypass out", bits, 4'b1010);

    // table: R4 R5 R6 R7 R8 R10
    for (int i = 0; i < NVEC; i++) begin
      logic [11:0] r;
      r = VEC[i];
      ext_req = r[7]; int_req = r[6];
      p0 = pulses;
      load(r[11:8]);
      chk($sformatf("R5/R6 hold row%0d", i), cfg_init_oe, r[5]);
      chk($sformatf("R10 ext_gnt row%0d", i), ext_gnt, r[4]);
      chk($sformatf("R5/R10 int_gnt row%0d", i), int_gnt, r[3]);
      chk($sformatf("R8 jtag_gnt row%0d", i), jtag_gnt, r[2]);
      chk($sformatf("R7 pulses row%0d", i), pulses - p0, r[1:0]);
    end

    // R11 data steering, external owner
    ext_req = 1; int_req = 0; ext_wen = 1; ext_wdata = 16'hA5A5;
    flash_dq_i = 16'h1234; jtag_wdata = 16'h5A5A;
    repeat (10) @(negedge clk);
    chk("R11 ext oe", flash_dq_oe, 16'hFFFF);
    chk("R11 ext data", flash_dq_o, 16'hA5A5);
    chk("R11 ext rdata", ext_rdata, 16'h1234);
    // R11 internal reader never drives
    ext_req = 0; int_req = 1;
    repeat (10) @(negedge clk);
    chk("R11 int gnt", int_gnt, 1);
    chk("R11 int no drive", flash_dq_oe, 0);
    chk("R11 int rdata zero", ext_rdata, 0);
    // R8 programming session blocks external drive
    ext_req = 1;
    load(4'h3);
    chk("R8 ext_wen blocked", flash_dq_oe, 0);
    chk("R8 rdata zero", ext_rdata, 0);
    jtag_wen = 1;
    repeat (10) @(negedge clk);
    chk("R11 jtag oe", flash_dq_oe, 16'hFFFF);
    chk("R11 jtag data", flash_dq_o, 16'h5A5A);
    jtag_wen = 0; ext_wen = 0;

    // R9/R2 reset of TAP during session keeps hold and JTAG ownership
    load(4'h1);
    p0 = pulses;
    reset_from_dr();
    chk("R9 hold kept", cfg_init_oe, 1);
    chk("R9 jtag kept", jtag_gnt, 1);
    chk("R9 no pulse", pulses - p0, 0);
    // coincident release and handoff
    ext_req = 1; int_req = 1;
    p0 = pulses;
    load(4'h2);
    chk("R7 release pulse", pulses - p0, 1);
    chk("R6 released", cfg_init_oe, 0);
    chk("R10 ext wins", {ext_gnt, int_gnt, jtag_gnt}, 3'b100);

    // R9/R2 TAP reset releases hold when no session
    load(4'h1);
    chk("R5 held again", cfg_init_oe, 1);
    p0 = pulses;
    reset_from_dr();
    chk("R9 hold released", cfg_init_oe, 0);
    chk("R7 reset pulse", pulses - p0, 1);
    ext_req = 0;
    load(4'h1);
    chk("R2 scan after reset", cfg_init_oe, 1);
    repeat (10) @(negedge clk);
    chk("R5 reader blocked", int_gnt, 0);

    done = 1'b1;
    finish_run();
  end
endmodule